// File: doc/BRIEF.md
# Reorder Buffer with Incremental Squash

This block is a circular reorder buffer for an out-of-order core. Dispatch writes instructions at the tail. Each instruction carries a PC, a next-PC and a sequence number. The slot index an instruction receives is returned at the moment it is accepted. Execution later marks that slot ready by index. The commit stage then retires the oldest entry from the head, but only once that entry is ready.

A squash request names a sequence number. The buffer does not drop the younger entries at once. A walker starts at the youngest entry and moves toward the head, handling up to `SQW` entries per cycle. Each entry it visits is flagged as squashed and also made ready. These entries then leave through the normal retire port, and a flag on that port tells the commit stage to discard their results.

The walk stops at the entry whose sequence number matches, and that entry is left alone. If the walk reaches the head without finding a match, it flags the head and stops there. New dispatch is held off while a walk is running. Retirement keeps going during the walk.

Top module: `reorder_buf`

## Requirements
- R1: `insReady` is low whenever the buffer holds `DEPTH` entries. After reset it is high.
- R2: `freeCount` always equals `DEPTH` minus the number of entries held. It reads `DEPTH` after reset.
- R3: `headReady` is high only when the buffer is not empty and its oldest entry has been marked ready. A `retValid` seen while `headReady` is low has no effect: `freeCount` and the head fields stay the same.
- R4: A squash walk handles at most `SQW` entries per cycle. The matching entry or the head counts as one of these. `squashDone` therefore stays low for ceil(visited/`SQW`) cycles.
- R5: The walk stops at the entry whose sequence number equals `sqSeq`. That entry is not squashed and retires with `retSquashed` low.
- R6: Each entry the walk passes over becomes squashed and ready. These entries retire in order, with `retSquashed` high.
- R7: `squashDone` is high after reset. It drops in the cycle after a squash request is accepted on a non-empty buffer, and rises again once the walk ends.
- R8: If no entry matches `sqSeq`, the walk flags every entry down to and including the head, and then ends.
- R9: `headPc`, `headNextPc` and `headSeq` show the oldest entry. `tailPc` and `tailSeq` show the youngest entry.
- R10: `insReady` is low while `sqValid` is high and for as long as a walk runs. Ready head entries still retire during a walk.
- R11: An insert and a retire in the same cycle leave `freeCount` unchanged.
- R12: `allocIdx` gives the slot the next insert will fill. It starts at 0 and advances by one, modulo `DEPTH`, on each insert. A pulse on `cmpValid` with `cmpIdx` marks that slot ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insValid | input | 1 | Dispatch request |
| insPc | input | PCW | PC of the dispatched instruction |
| insNextPc | input | PCW | Next-PC of the dispatched instruction |
| insSeq | input | SEQW | Sequence number of the dispatched instruction |
| insReady | output | 1 | Buffer can accept an insert this cycle |
| allocIdx | output | PTRW | Slot the next insert fills |
| cmpValid | input | 1 | Mark a slot ready to commit |
| cmpIdx | input | PTRW | Slot to mark ready |
| retValid | input | 1 | Retire the head if it is ready |
| retSquashed | output | 1 | Head entry is squashed |
| headReady | output | 1 | Head entry exists and is ready |
| headPc | output | PCW | PC of the oldest entry |
| headNextPc | output | PCW | Next-PC of the oldest entry |
| headSeq | output | SEQW | Sequence number of the oldest entry |
| tailPc | output | PCW | PC of the youngest entry |
| tailSeq | output | SEQW | Sequence number of the youngest entry |
| freeCount | output | CNTW | Number of free slots |
| sqValid | input | 1 | Squash request |
| sqSeq | input | SEQW | Sequence number the squash stops at |
| squashDone | output | 1 | No squash walk is in progress |

## Verification
The assertions rely on a few assumptions about the inputs:
- No squash request arrives while a walk is already running.
- `cmpValid` never names the slot being filled in the same cycle.
- `DEPTH` is a power of two and `SQW` is no larger than `DEPTH`.

The stimulus keeps within these limits. Each squash is issued only while `squashDone` is high. Ready marks are applied only to sequence numbers already in the scoreboard, and in cycles with no insert. Every walk is allowed to finish before the next request is made.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef struct packed {
    logic insEn;
    logic retEn;
    logic cmpEn;
    logic walkEn;
  } robStrobe_t;
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SQW   = 2,
  parameter int SEQW  = 16,
  localparam int PTRW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      insValid,
  input  logic                      retValid,
  input  logic                      cmpValid,
  input  logic                      sqValid,
  input  logic [SEQW-1:0]           sqSeq,
  input  logic                      headRdyBit,
  input  logic [SQW-1:0][SEQW-1:0]  walkSeq,
  output robStrobe_t                strobe,
  output logic [PTRW-1:0]           headPtr,
  output logic [PTRW-1:0]           tailPtr,
  output logic [PTRW-1:0]           walkPtr,
  output logic [SQW-1:0]            walkMark,
  output logic [CNTW-1:0]           freeCount,
  output logic                      insReady,
  output logic                      headReady,
  output logic                      squashDone
);
  logic [CNTW-1:0] count;
  logic            squashing;
  logic [SEQW-1:0] sqSeqReg;
  logic            insFire, retFire, walkEnd;
  logic [PTRW-1:0] walkOffset;
  logic            walkInRange;

  assign insReady   = (count != CNTW'(DEPTH)) && !squashing && !sqValid;
  assign headReady  = (count != '0) && headRdyBit;
  assign insFire    = insValid && insReady;
  assign retFire    = retValid && headReady;
  assign freeCount  = CNTW'(DEPTH) - count;
  assign squashDone = !squashing;

  assign walkOffset  = walkPtr - headPtr;
  assign walkInRange = CNTW'(walkOffset) < count;

  always_comb begin
    logic hit;
    hit      = 1'b0;
    walkMark = '0;
    for (int k = 0; k < SQW; k++) begin
      if (!hit && squashing && walkInRange && (CNTW'(k) <= CNTW'(walkOffset))) begin
        if (walkSeq[k] == sqSeqReg) begin
          hit = 1'b1;
        end else begin
          walkMark[k] = 1'b1;
          if (CNTW'(k) == CNTW'(walkOffset)) hit = 1'b1;
        end
      end
    end
    walkEnd = squashing && (!walkInRange || hit);
  end

  always_comb begin
    strobe.insEn  = insFire;
    strobe.retEn  = retFire;
    strobe.cmpEn  = cmpValid;
    strobe.walkEn = squashing;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '0;
      headPtr   <= '0;
      tailPtr   <= '0;
      walkPtr   <= '0;
      squashing <= 1'b0;
      sqSeqReg  <= '0;
    end else begin
      if (insFire) tailPtr <= tailPtr + 1'b1;
      if (retFire) headPtr <= headPtr + 1'b1;
      if (insFire && !retFire)      count <= count + 1'b1;
      else if (retFire && !insFire) count <= count - 1'b1;
      if (sqValid && !squashing) begin
        if (count != '0) begin
          squashing <= 1'b1;
          walkPtr   <= tailPtr - 1'b1;
          sqSeqReg  <= sqSeq;
        end
      end else if (squashing) begin
        if (walkEnd) squashing <= 1'b0;
        else         walkPtr   <= walkPtr - PTRW'(SQW);
      end
    end
  end

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNTW'(DEPTH));

  p_free_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (insFire && !retFire) |=> (freeCount == $past(freeCount) - 1'b1));

  p_same_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (insFire && retFire) |=> (freeCount == $past(freeCount)));

  p_done_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(squashDone) |-> $past(sqValid));
endmodule

// File: rtl/rob_data.sv
module rob_data
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SQW   = 2,
  parameter int PCW   = 32,
  parameter int SEQW  = 16,
  localparam int PTRW = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  robStrobe_t                strobe,
  input  logic [PTRW-1:0]           headPtr,
  input  logic [PTRW-1:0]           tailPtr,
  input  logic [PTRW-1:0]           walkPtr,
  input  logic [SQW-1:0]            walkMark,
  input  logic [PTRW-1:0]           cmpIdx,
  input  logic [PCW-1:0]            insPc,
  input  logic [PCW-1:0]            insNextPc,
  input  logic [SEQW-1:0]           insSeq,
  output logic [PCW-1:0]            headPc,
  output logic [PCW-1:0]            headNextPc,
  output logic [SEQW-1:0]           headSeq,
  output logic                      headRdyBit,
  output logic                      headSq,
  output logic [PCW-1:0]            tailPc,
  output logic [SEQW-1:0]           tailSeq,
  output logic [SQW-1:0][SEQW-1:0]  walkSeq
);
  logic [PCW-1:0]  pcMem   [DEPTH];
  logic [PCW-1:0]  npcMem  [DEPTH];
  logic [SEQW-1:0] seqMem  [DEPTH];
  logic [DEPTH-1:0] rdyBits;
  logic [DEPTH-1:0] sqBits;
  logic [PTRW-1:0] youngIdx;

  assign youngIdx   = tailPtr - 1'b1;
  assign headPc     = pcMem[headPtr];
  assign headNextPc = npcMem[headPtr];
  assign headSeq    = seqMem[headPtr];
  assign headRdyBit = rdyBits[headPtr];
  assign headSq     = sqBits[headPtr];
  assign tailPc     = pcMem[youngIdx];
  assign tailSeq    = seqMem[youngIdx];

  for (genvar k = 0; k < SQW; k++) begin : g_walk
    assign walkSeq[k] = seqMem[walkPtr - PTRW'(k)];
  end

  always_ff @(posedge clk) begin
    if (strobe.insEn) begin
      pcMem[tailPtr]  <= insPc;
      npcMem[tailPtr] <= insNextPc;
      seqMem[tailPtr] <= insSeq;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdyBits <= '0;
      sqBits  <= '0;
    end else begin
      if (strobe.insEn) begin
        rdyBits[tailPtr] <= 1'b0;
        sqBits[tailPtr]  <= 1'b0;
      end
      if (strobe.cmpEn) rdyBits[cmpIdx] <= 1'b1;
      for (int k = 0; k < SQW; k++) begin
        if (strobe.walkEn && walkMark[k]) begin
          rdyBits[walkPtr - PTRW'(k)] <= 1'b1;
          sqBits[walkPtr - PTRW'(k)]  <= 1'b1;
        end
      end
    end
  end

  p_walk_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.walkEn && walkMark[0]) |=> (sqBits[$past(walkPtr)] && rdyBits[$past(walkPtr)]));
endmodule

// File: rtl/reorder_buf.sv
module reorder_buf
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SQW   = 2,
  parameter int PCW   = 32,
  parameter int SEQW  = 16,
  localparam int PTRW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insValid,
  input  logic [PCW-1:0]  insPc,
  input  logic [PCW-1:0]  insNextPc,
  input  logic [SEQW-1:0] insSeq,
  output logic            insReady,
  output logic [PTRW-1:0] allocIdx,
  input  logic            cmpValid,
  input  logic [PTRW-1:0] cmpIdx,
  input  logic            retValid,
  output logic            retSquashed,
  output logic            headReady,
  output logic [PCW-1:0]  headPc,
  output logic [PCW-1:0]  headNextPc,
  output logic [SEQW-1:0] headSeq,
  output logic [PCW-1:0]  tailPc,
  output logic [SEQW-1:0] tailSeq,
  output logic [CNTW-1:0] freeCount,
  input  logic            sqValid,
  input  logic [SEQW-1:0] sqSeq,
  output logic            squashDone
);
  robStrobe_t               strobe;
  logic [PTRW-1:0]          headPtr, tailPtr, walkPtr;
  logic [SQW-1:0]           walkMark;
  logic [SQW-1:0][SEQW-1:0] walkSeq;
  logic                     headRdyBit;

  assign allocIdx = tailPtr;

  rob_ctrl #(.DEPTH(DEPTH), .SQW(SQW), .SEQW(SEQW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .insValid(insValid), .retValid(retValid),
    .cmpValid(cmpValid), .sqValid(sqValid), .sqSeq(sqSeq),
    .headRdyBit(headRdyBit), .walkSeq(walkSeq), .strobe(strobe),
    .headPtr(headPtr), .tailPtr(tailPtr), .walkPtr(walkPtr),
    .walkMark(walkMark), .freeCount(freeCount), .insReady(insReady),
    .headReady(headReady), .squashDone(squashDone)
  );

  rob_data #(.DEPTH(DEPTH), .SQW(SQW), .PCW(PCW), .SEQW(SEQW)) u_data (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .headPtr(headPtr),
    .tailPtr(tailPtr), .walkPtr(walkPtr), .walkMark(walkMark),
    .cmpIdx(cmpIdx), .insPc(insPc), .insNextPc(insNextPc), .insSeq(insSeq),
    .headPc(headPc), .headNextPc(headNextPc), .headSeq(headSeq),
    .headRdyBit(headRdyBit), .headSq(retSquashed), .tailPc(tailPc),
    .tailSeq(tailSeq), .walkSeq(walkSeq)
  );
endmodule

// File: tb/reorder_buf_tb.sv
module reorder_buf_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int SQW   = 2;
  localparam int PCW   = 32;
  localparam int SEQW  = 16;
  localparam int PTRW  = $clog2(DEPTH);
  localparam int CNTW  = $clog2(DEPTH + 1);

  typedef struct {
    int seq;
    logic [PCW-1:0] pc;
    int idx;
    logic sq;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic insValid = 0, cmpValid = 0, retValid = 0, sqValid = 0;
  logic [PCW-1:0] insPc = 0, insNextPc = 0;
  logic [SEQW-1:0] insSeq = 0, sqSeq = 0;
  logic [PTRW-1:0] cmpIdx = 0;
  logic insReady, retSquashed, headReady, squashDone;
  logic [PTRW-1:0] allocIdx;
  logic [PCW-1:0] headPc, headNextPc, tailPc;
  logic [SEQW-1:0] headSeq, tailSeq;
  logic [CNTW-1:0] freeCount;

  int checks = 0, fails = 0, tailCnt = 0;
  item_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  reorder_buf #(.DEPTH(DEPTH), .SQW(SQW), .PCW(PCW), .SEQW(SEQW)) u_dut (
    .clk(clk), .rst_n(rst_n), .insValid(insValid), .insPc(insPc),
    .insNextPc(insNextPc), .insSeq(insSeq), .insReady(insReady),
    .allocIdx(allocIdx), .cmpValid(cmpValid), .cmpIdx(cmpIdx),
    .retValid(retValid), .retSquashed(retSquashed), .headReady(headReady),
    .headPc(headPc), .headNextPc(headNextPc), .headSeq(headSeq),
    .tailPc(tailPc), .tailSeq(tailSeq), .freeCount(freeCount),
    .sqValid(sqValid), .sqSeq(sqSeq), .squashDone(squashDone)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [PCW-1:0] pcOf(input int seq);
    return 32'h1000 + PCW'(seq) * 4;
  endfunction

  // monitor: pops the scoreboard on every accepted retirement
  always @(negedge clk) begin
    if (rst_n && retValid && headReady) begin
      if (sbq.size() == 0) begin
        chk(0, "R6 retire with empty scoreboard", headSeq, -1);
      end else begin
        item_t e;
        e = sbq.pop_front();
        chk(headSeq == SEQW'(e.seq) && headPc == e.pc && headNextPc == e.pc + 4,
            "R9 retired head fields", headSeq, e.seq);
        chk(retSquashed == e.sq, e.sq ? "R6 squashed flag" : "R5 unsquashed flag",
            retSquashed, e.sq);
      end
    end
  end

  task automatic doInsert(input int seq);
    item_t e;
    chk(insReady == 1, "R1 insReady before insert", insReady, 1);
    chk(allocIdx == PTRW'(tailCnt), "R12 allocIdx", allocIdx, tailCnt % DEPTH);
    e.seq = seq; e.pc = pcOf(seq); e.idx = tailCnt % DEPTH; e.sq = 0;
    sbq.push_back(e);
    tailCnt++;
    insValid = 1; insPc = e.pc; insNextPc = e.pc + 4; insSeq = SEQW'(seq);
    @(posedge clk); #1;
    insValid = 0;
  endtask

  task automatic doComplete(input int seq);
    int idx = -1;
    foreach (sbq[i]) if (sbq[i].seq == seq) idx = sbq[i].idx;
    cmpValid = 1; cmpIdx = PTRW'(idx);
    @(posedge clk); #1;
    cmpValid = 0;
  endtask

  task automatic doRetire();
    retValid = 1;
    @(posedge clk); #1;
    retValid = 0;
  endtask

  task automatic doSquash(input int seq, input bit holdRet, input int expCycles, input string req);
    int cnt = 0;
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].seq == seq) break;
      sbq[i].sq = 1;
    end
    sqValid = 1; sqSeq = SEQW'(seq);
    #1;
    chk(insReady == 0, "R10 insReady low with sqValid", insReady, 0);
    @(posedge clk); #1;
    sqValid = 0;
    chk(squashDone == 0, "R7 squashDone drops", squashDone, 0);
    retValid = holdRet;
    while (!squashDone && cnt < 50) begin
      cnt++;
      chk(insReady == 0, "R10 insReady low during walk", insReady, 0);
      @(posedge clk); #1;
    end
    retValid = 0;
    chk(cnt == expCycles, req, cnt, expCycles);
    chk(squashDone == 1, "R7 squashDone rises", squashDone, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // reset state
    chk(freeCount == DEPTH, "R2 reset freeCount", freeCount, DEPTH);
    chk(headReady == 0, "R3 reset headReady", headReady, 0);
    chk(squashDone == 1, "R7 reset squashDone", squashDone, 1);
    chk(insReady == 1, "R1 reset insReady", insReady, 1);
    chk(allocIdx == 0, "R12 reset allocIdx", allocIdx, 0);

    // basic insert, head/tail fields, ready gating
    doInsert(10); doInsert(11); doInsert(12);
    chk(freeCount == 5, "R2 freeCount after 3 inserts", freeCount, 5);
    chk(headSeq == 10 && headPc == pcOf(10) && headNextPc == pcOf(10) + 4, "R9 head fields", headSeq, 10);
    chk(tailSeq == 12 && tailPc == pcOf(12), "R9 tail fields", tailSeq, 12);
    chk(headReady == 0, "R3 head not ready", headReady, 0);
    doRetire();
    chk(freeCount == 5 && headSeq == 10, "R3 retire ignored when not ready", freeCount, 5);
    doComplete(11);
    chk(headReady == 0, "R12 younger completion leaves head unready", headReady, 0);
    doComplete(10);
    chk(headReady == 1, "R12 R3 head ready after completion", headReady, 1);
    doComplete(12);
    doRetire(); doRetire(); doRetire();
    chk(freeCount == DEPTH && headReady == 0, "R2 R3 drained", freeCount, DEPTH);

    // fill, then squash while retiring
    for (int s = 20; s < 28; s++) doInsert(s);
    chk(freeCount == 0, "R2 full freeCount", freeCount, 0);
    chk(insReady == 0, "R1 full blocks insert", insReady, 0);
    doComplete(20);
    doSquash(22, 1, 3, "R4 walk cycles with match");
    chk(headSeq == 21, "R10 retirement during walk", headSeq, 21);
    doComplete(21); doComplete(22);
    for (int i = 0; i < 7; i++) doRetire();
    chk(freeCount == DEPTH, "R5 R6 drained after squash", freeCount, DEPTH);

    // squash with no matching entry reaches the head
    for (int s = 30; s < 34; s++) doInsert(s);
    doSquash(7, 0, 2, "R8 R4 walk cycles to head");
    chk(headReady == 1 && retSquashed == 1, "R8 head flagged", retSquashed, 1);
    for (int i = 0; i < 4; i++) doRetire();
    chk(freeCount == DEPTH, "R8 drained", freeCount, DEPTH);

    // insert and retire in one cycle
    doInsert(40);
    doComplete(40);
    begin
      item_t e;
      e.seq = 41; e.pc = pcOf(41); e.idx = tailCnt % DEPTH; e.sq = 0;
      sbq.push_back(e);
      tailCnt++;
      insValid = 1; insPc = e.pc; insNextPc = e.pc + 4; insSeq = 41;
      retValid = 1;
      @(posedge clk); #1;
      insValid = 0; retValid = 0;
    end
    chk(freeCount == DEPTH - 1, "R11 simultaneous insert and retire", freeCount, DEPTH - 1);
    chk(headSeq == 41 && tailSeq == 41, "R11 R9 single entry", headSeq, 41);
    doComplete(41);
    doRetire();
    chk(freeCount == DEPTH, "R2 final freeCount", freeCount, DEPTH);
    chk(sbq.size() == 0, "R6 scoreboard empty", sbq.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule